// File: doc/BRIEF.md
# Write-Through Write-Allocate Data Cache

This block is a small fully associative data cache placed between a byte-addressed processor load/store port and a memory port that moves one byte per handshake. Each of the two lines holds a two-byte block, a 4-bit tag and a valid bit. A load or store that misses brings the whole block in from memory, one byte per read, into a victim line. Stores use write-through. Every store updates the cached byte and also sends that one byte to memory. Because memory always holds current data, a line can be dropped on eviction without any memory write, and no dirty state exists.

The processor raises a request while `cpu_busy` is low. A load hit returns its byte one cycle later on a single-cycle `cpu_rvalid` pulse. A miss holds `cpu_busy` high for the block fill. A store also holds `cpu_busy` high for its memory write. Two counters report hits and misses.

Top module: `wt_alloc_cache`

## Requirements
- R1: After reset `cpu_busy`, `cpu_rvalid`, `hit_count` and `miss_count` are 0 and every line is invalid, so the first access to any address misses.
- R2: A load miss issues exactly two memory reads, one for each byte of the 2-byte block (block base = address with bit 0 cleared). It then returns the addressed byte with one `cpu_rvalid` pulse in the cycle in which `cpu_busy` falls.
- R3: A load hit makes no memory access, keeps `cpu_busy` low and pulses `cpu_rvalid` with the cached byte in the cycle after the request is accepted.
- R4: A store hit updates the cached byte and makes exactly one memory write of that byte at the store address, with no memory read.
- R5: A store miss first fills the block (two reads), merges the stored byte into it and then makes exactly one memory write. A later access to either byte of that block hits.
- R6: Evicting a line never writes memory, and data reloaded after eviction equals the last stored value.
- R7: When both lines are valid, a miss replaces the least recently used line. A hit or a completed fill makes that line the most recently used.
- R8: An invalid line is always chosen as the victim before any valid line.
- R9: Each accepted access increments exactly one of `hit_count` or `miss_count` by one.
- R10: `cpu_busy` is high throughout a fill or a memory write. A request raised while `cpu_busy` is high is ignored: it changes no counter, cache content or memory.
- R11: `cpu_rvalid` pulses for exactly one cycle, once per load, and never for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when cpu_busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_busy | output | 1 | Cache is filling or writing memory |
| cpu_rvalid | output | 1 | Load data valid, one cycle |
| cpu_rdata | output | 8 | Load data |
| mem_req | output | 1 | Memory request, held until mem_ready |
| mem_we | output | 1 | 1 = memory write, 0 = read |
| mem_addr | output | 5 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with mem_ready |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |

## Verification
The counters step at the clock edge that accepts a request. A load hit's `cpu_rvalid` follows one edge later. After a miss, the pulse lands on the same edge at which the last fill byte arrives and `cpu_busy` drops. The bench drives and samples on falling edges only. It counts `cpu_rvalid` pulses and memory transfers continuously, and it compares their totals only after `cpu_busy` has been seen low for a full extra cycle, so every result has had time to appear. `cpu_busy` is sampled one half-cycle after acceptance, where a miss or a store must already show it high.

// File: rtl/wac_pkg.sv
package wac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2
    } wac_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wac_lookup.sv
module wac_lookup #(
    parameter int LINES = 2,
    parameter int TAG_W = 4,
    parameter int IDX_W = 1
) (
    input  logic [LINES-1:0]            valid,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            tag_in,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [LINES-1:0] match;

    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == tag_in);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/wac_lru.sv
module wac_lru #(
    parameter int LINES = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch,
    input  logic [IDX_W-1:0] touch_idx,
    input  logic [LINES-1:0] valid,
    output logic [IDX_W-1:0] victim
);
    logic [LINES-1:0][IDX_W-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(LINES - 1 - i);
        end else if (touch) begin
            for (int i = 0; i < LINES; i++) begin
                if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    always_comb begin
        logic found;
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (age_q[i] == IDX_W'(LINES - 1)) victim = IDX_W'(i);
        end
        for (int i = 0; i < LINES; i++) begin
            if (!valid[i] && !found) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wt_alloc_cache.sv
module wt_alloc_cache
    import wac_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int ITEM_W    = 8,
    parameter int LINES     = 2,
    parameter int BLK_ITEMS = 2,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [ITEM_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_rvalid,
    output logic [ITEM_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ITEM_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [ITEM_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int OFF_W = $clog2(BLK_ITEMS);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = idx_width(LINES);
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(BLK_ITEMS - 1);

    wac_state_e                  state_q;
    logic [LINES-1:0]            valid_q;
    logic [LINES-1:0][TAG_W-1:0] tag_q;
    logic [ITEM_W-1:0]           data_q [LINES][BLK_ITEMS];

    logic              req_we_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [ITEM_W-1:0] req_wdata_q;
    logic [IDX_W-1:0]  line_q;
    logic [OFF_W-1:0]  beat_q;
    logic              rvalid_q;
    logic [ITEM_W-1:0] rdata_q;

    logic [TAG_W-1:0] tag_in;
    logic [OFF_W-1:0] off_in;
    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim;
    logic             accept;
    logic             beat_done;
    logic             fill_done;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;

    assign tag_in    = cpu_addr[ADDR_W-1:OFF_W];
    assign off_in    = cpu_addr[OFF_W-1:0];
    assign req_tag   = req_addr_q[ADDR_W-1:OFF_W];
    assign req_off   = req_addr_q[OFF_W-1:0];
    assign accept    = (state_q == ST_IDLE) && cpu_req;
    assign beat_done = (state_q == ST_FILL) && mem_ready;
    assign fill_done = beat_done && (beat_q == LAST_BEAT);
    assign touch     = (accept && hit) || fill_done;
    assign touch_idx = fill_done ? line_q : hit_idx;

    wac_lookup #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) lookup_i (
        .valid   (valid_q),
        .tags    (tag_q),
        .tag_in  (tag_in),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    wac_lru #(.LINES(LINES), .IDX_W(IDX_W)) lru_i (
        .clk       (clk),
        .rst       (rst),
        .touch     (touch),
        .touch_idx (touch_idx),
        .valid     (valid_q),
        .victim    (victim)
    );

    // Control, tags, counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            valid_q     <= '0;
            tag_q       <= '0;
            req_we_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            line_q      <= '0;
            beat_q      <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
            hit_count   <= '0;
            miss_count  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req) begin
                        req_we_q    <= cpu_we;
                        req_addr_q  <= cpu_addr;
                        req_wdata_q <= cpu_wdata;
                        if (hit) begin
                            hit_count <= hit_count + 1'b1;
                            if (cpu_we) begin
                                state_q <= ST_WRITE;
                            end else begin
                                rvalid_q <= 1'b1;
                                rdata_q  <= data_q[hit_idx][off_in];
                            end
                        end else begin
                            miss_count      <= miss_count + 1'b1;
                            line_q          <= victim;
                            valid_q[victim] <= 1'b0;
                            tag_q[victim]   <= tag_in;
                            beat_q          <= '0;
                            state_q         <= ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ready) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == LAST_BEAT) begin
                            valid_q[line_q] <= 1'b1;
                            if (req_we_q) begin
                                state_q <= ST_WRITE;
                            end else begin
                                state_q  <= ST_IDLE;
                                rvalid_q <= 1'b1;
                                rdata_q  <= (req_off == beat_q) ? mem_rdata
                                                                : data_q[line_q][req_off];
                            end
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line data array, no reset needed: guarded by valid bits
    always_ff @(posedge clk) begin
        if (accept && hit && cpu_we) begin
            data_q[hit_idx][off_in] <= cpu_wdata;
        end
        if (beat_done) begin
            data_q[line_q][beat_q] <= mem_rdata;
            if (fill_done && req_we_q) begin
                data_q[line_q][req_off] <= req_wdata_q;
            end
        end
    end

    assign cpu_busy   = (state_q != ST_IDLE);
    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;
    assign mem_req    = (state_q != ST_IDLE);
    assign mem_we     = (state_q == ST_WRITE);
    assign mem_addr   = (state_q == ST_WRITE) ? req_addr_q : {req_tag, beat_q};
    assign mem_wdata  = req_wdata_q;
endmodule

// File: rtl/wac_checker.sv
module wac_checker #(
    parameter int ADDR_W = 5,
    parameter int ITEM_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_busy,
    input logic              cpu_rvalid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ITEM_W-1:0] mem_wdata,
    input logic              mem_ready,
    input logic [CNT_W-1:0]  hit_count,
    input logic [CNT_W-1:0]  miss_count
);
    // R11: load data valid lasts one cycle
    a_r11_rvalid_single: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |=> !cpu_rvalid);

    // R9: never both counters in one cycle
    a_r9_one_counter_step: assert property (@(posedge clk) disable iff (rst)
        !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));

    // R10: requests while busy change no counter
    a_r10_busy_ignores_req: assert property (@(posedge clk) disable iff (rst)
        cpu_busy |=> ($stable(hit_count) && $stable(miss_count)));

    // R10: memory activity only while busy
    a_r10_mem_implies_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_busy);

    // R2: a pending memory request holds its address and data
    a_r2_mem_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    // R4: one memory write per store, then the port goes quiet
    a_r4_single_write: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> !mem_req);

    // R11: no load data while a fill or write is still running
    a_r11_no_rvalid_busy: assert property (@(posedge clk) disable iff (rst)
        cpu_rvalid |-> !cpu_busy);
endmodule

bind wt_alloc_cache wac_checker #(
    .ADDR_W (ADDR_W),
    .ITEM_W (ITEM_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cpu_busy   (cpu_busy),
    .cpu_rvalid (cpu_rvalid),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready),
    .hit_count  (hit_count),
    .miss_count (miss_count)
);

// File: tb/wt_alloc_cache_tb_top.sv
`timescale 1ns/1ps
module wt_alloc_cache_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_busy, cpu_rvalid;
    logic [7:0] cpu_rdata;
    logic       mem_req, mem_we;
    logic [4:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_ready = 1'b0;
    logic [7:0] mem_rdata = '0;
    logic [15:0] hit_count, miss_count;

    always #5 clk = ~clk;

    wt_alloc_cache dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_busy(cpu_busy),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] mem_model [32];
    logic [7:0] gold [32];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int rv_cnt = 0;
    logic [7:0] rv_data = '0;
    int lat = 0;

    // Memory model: one wait cycle, then ready for one cycle
    always @(negedge clk) begin
        if (rst) begin
            mem_ready = 1'b0;
            lat = 0;
        end else if (mem_ready) begin
            mem_ready = 1'b0;
        end else if (mem_req) begin
            if (lat == 1) begin
                lat = 0;
                mem_ready = 1'b1;
                if (mem_we) begin
                    mem_model[mem_addr] = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem_model[mem_addr];
                    rd_cnt++;
                end
            end else begin
                lat++;
            end
        end
    end

    always @(negedge clk) begin
        if (cpu_rvalid) begin
            rv_cnt++;
            rv_data = cpu_rdata;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_idle();
        while (cpu_busy) step();
        step();
    endtask

    // One access with full expectation check
    task automatic do_op(input string req, input logic we, input logic [4:0] a,
                         input logic [7:0] d, input logic exp_hit);
        int h0, m0, r0, w0, v0;
        logic busy_seen;
        wait_idle();
        h0 = hit_count; m0 = miss_count; r0 = rd_cnt; w0 = wr_cnt; v0 = rv_cnt;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        step();
        cpu_req = 1'b0;
        busy_seen = cpu_busy;
        wait_idle();
        if (we) gold[a] = d;
        chk(req, "hits", int'(hit_count) - h0, exp_hit ? 1 : 0);
        chk("R9", "misses", int'(miss_count) - m0, exp_hit ? 0 : 1);
        chk(exp_hit ? "R3" : "R2", "mem reads", rd_cnt - r0, exp_hit ? 0 : 2);
        chk(we ? "R4" : "R6", "mem writes", wr_cnt - w0, we ? 1 : 0);
        chk("R11", "rvalid pulses", rv_cnt - v0, we ? 0 : 1);
        chk("R10", "busy after accept", int'(busy_seen), (exp_hit && !we) ? 0 : 1);
        if (!we) chk(req, "load data", int'(rv_data), int'(gold[a]));
        else     chk(req, "memory byte", int'(mem_model[a]), int'(d));
    endtask

    typedef struct packed {
        logic       we;
        logic [4:0] addr;
        logic [7:0] wd;
        logic       hit;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 5'd1,  8'h00, 1'b0},  // R1/R2 cold load miss
        '{1'b0, 5'd7,  8'h00, 1'b0},  // R8 goes to invalid line
        '{1'b1, 5'd0,  8'hAB, 1'b1},  // R4 store hit
        '{1'b1, 5'd5,  8'h5C, 1'b0},  // R5 store miss, evicts block 3
        '{1'b0, 5'd10, 8'h00, 1'b0},  // R7 evicts block 0
        '{1'b0, 5'd4,  8'h00, 1'b1},  // R5 neighbour of allocated store hits
        '{1'b1, 5'd11, 8'h11, 1'b1},  // R4 store hit
        '{1'b0, 5'd0,  8'h00, 1'b0},  // R6 reload after eviction, R7 evicts block 2
        '{1'b0, 5'd11, 8'h00, 1'b1},  // R3 load hit
        '{1'b0, 5'd5,  8'h00, 1'b0}   // R6 reload stored byte
    };

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem_model[i] = 8'((i * 37 + 11) & 255);
            gold[i]      = 8'((i * 37 + 11) & 255);
        end
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk("R1", "hit_count", int'(hit_count), 0);
        chk("R1", "miss_count", int'(miss_count), 0);
        chk("R1", "busy", int'(cpu_busy), 0);
        chk("R1", "rvalid", int'(cpu_rvalid), 0);

        for (int k = 0; k < NVEC; k++) begin
            do_op($sformatf("R7 vec%0d", k), VEC[k].we, VEC[k].addr, VEC[k].wd, VEC[k].hit);
        end
        chk("R9", "total hits", int'(hit_count), 4);
        chk("R9", "total misses", int'(miss_count), 6);

        // R10: request pulsed while busy is ignored
        begin
            int m0, h0, w0, v0;
            wait_idle();
            m0 = miss_count; h0 = hit_count; w0 = wr_cnt; v0 = rv_cnt;
            cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 5'd20;
            step();
            cpu_req = 1'b0;
            step();
            cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 5'd0; cpu_wdata = 8'hEE;
            step();
            cpu_req = 1'b0; cpu_we = 1'b0;
            wait_idle();
            chk("R10", "misses during busy", int'(miss_count) - m0, 1);
            chk("R10", "hits during busy", int'(hit_count) - h0, 0);
            chk("R10", "writes during busy", wr_cnt - w0, 0);
            chk("R10", "load pulses", rv_cnt - v0, 1);
            chk("R10", "load data", int'(rv_data), int'(gold[20]));
            chk("R10", "memory untouched", int'(mem_model[0]), int'(gold[0]));
        end
        do_op("R10 ignored store absent", 1'b0, 5'd0, 8'h00, 1'b0);

        // R1: reset mid-run clears counters and invalidates lines
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        step();
        chk("R1", "hit_count after reset", int'(hit_count), 0);
        chk("R1", "miss_count after reset", int'(miss_count), 0);
        chk("R1", "busy after reset", int'(cpu_busy), 0);
        do_op("R1 cached address misses after reset", 1'b0, 5'd0, 8'h00, 1'b0);
        do_op("R8 second block into invalid line", 1'b0, 5'd30, 8'h00, 1'b0);
        do_op("R8 first block still present", 1'b0, 5'd1, 8'h00, 1'b1);

        finish_run();
    end
endmodule